// File: doc/BRIEF.md
# Five-Port Binary Byte Writer

This block sits behind the listener side of an instrument bus and handles the high-speed binary data mode. While binary mode is active, the command interpreter is switched off. Every byte the listener hands over is treated as port data. Bytes are written straight into five 8-bit output port registers, starting at the highest port and moving down. A data strobe of fixed length is issued when a group of five bytes is complete. It is also issued when a byte flagged as end-of-message arrives before the group is full.

Binary mode is entered on a request from the surrounding command logic. It is left only through a device-clear event. In binary mode, a clear hands control back to the text format and leaves the port contents untouched. In text mode, a clear wipes the ports to their default of zero and pulses a clear output for a fixed time. In text mode the block ignores listener bytes, because they belong to the command parser.

Top module: `bin_port_writer`

## Requirements
- R1: After reset the ports are all zero, the block is in text mode (`bin_mode_o`=0), and `strobe_o` and `clr_pulse_o` are low.
- R2: `bin_enter_i` in text mode, without a clear in the same cycle, sets `bin_mode_o` from the next clock edge.
- R3: In binary mode each accepted byte is stored at the clock edge that samples it. Bytes fill the ports in the order port 5, 4, 3, 2, 1. On `port_data_o`, port k occupies bits [8k-1 : 8k-8], so port 5 is [39:32] and port 1 is [7:0].
- R4: `strobe_o` stays low until a group completes. When the fifth byte is stored, `strobe_o` rises at that same edge and stays high for exactly STB_CYCLES cycles.
- R5: A byte with `byte_eom_i`=1 ends the group early and strobes as in R4. Ports that the short group did not reach keep their previous values.
- R6: After any group completes, whether full or early, the next byte goes to port 5.
- R7: Bytes that arrive while the strobe is high are stored into the next group. When that group completes, the strobe stays high and runs a full STB_CYCLES from the new completion edge.
- R8: In text mode, bytes from the listener have no effect on the ports or on the strobe.
- R9: A clear in binary mode returns the block to text mode at the next edge. It does not pulse `clr_pulse_o`, leaves the ports unchanged, and sends the next binary byte to port 5.
- R10: A clear in text mode sets all ports to zero and drives `clr_pulse_o` high for exactly CLR_CYCLES cycles.
- R11: A byte that arrives in binary mode in the same cycle as a clear is still stored. If that byte completes a group, it strobes, and the mode still returns to text.
- R12: If a clear and `bin_enter_i` arrive in the same cycle, the clear wins and the block stays in text mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bin_enter_i | input | 1 | Request from the command logic to enter binary mode |
| dev_clr_i | input | 1 | Device clear or selected device clear event, one cycle |
| byte_valid_i | input | 1 | Listener byte valid, one cycle per byte |
| byte_eom_i | input | 1 | The current byte ends the message |
| byte_data_i | input | 8 | Listener byte |
| port_data_o | output | 40 | Five port registers, port 5 in the top byte |
| strobe_o | output | 1 | Data strobe |
| clr_pulse_o | output | 1 | Clear output pulse |
| bin_mode_o | output | 1 | 1 while binary mode is active |

## Verification
Group completion and the binary-mode exit can happen in the same cycle. The bench provokes this by sending four bytes and then the fifth byte together with a clear. It then checks three things one cycle later: the fifth byte sits in port 1, the strobe is high, and the mode is text. It also checks that the clear pulse stays low for the following cycles. A second case places a clear after a partial group. This shows that the ports keep their contents and that the position rewinds to port 5.

// File: rtl/bpw_pkg.sv
package bpw_pkg;
  typedef enum logic {
    MODE_TEXT = 1'b0,
    MODE_BIN  = 1'b1
  } mode_e;
endpackage

// File: rtl/bpw_pulse_timer.sv
module bpw_pulse_timer #(
  parameter int unsigned CYCLES = 750
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  output logic active_o
);
  localparam int unsigned CW = $clog2(CYCLES + 1);
  localparam logic [CW-1:0] LOAD_VAL = CW'(CYCLES);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (load_i)          cnt_q <= LOAD_VAL;  // restart on every load
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign active_o = (cnt_q != '0);

  assert_cnt_bound_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LOAD_VAL);
  assert_load_active_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> active_o);
  assert_pulse_ends_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && cnt_q == CW'(1)) |=> !active_o);
endmodule

// File: rtl/bpw_mode_ctrl.sv
module bpw_mode_ctrl
  import bpw_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  enter_i,
  input  logic  clr_i,
  output mode_e mode_o,
  output logic  clr_fire_o,
  output logic  exit_o
);
  mode_e mode_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      mode_q <= MODE_TEXT;
    else if (clr_i)   mode_q <= MODE_TEXT;  // clear beats enter
    else if (enter_i) mode_q <= MODE_BIN;
  end

  assign mode_o     = mode_q;
  assign clr_fire_o = clr_i && (mode_q == MODE_TEXT);
  assign exit_o     = clr_i && (mode_q == MODE_BIN);

  assert_clr_to_text_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> mode_q == MODE_TEXT);
  assert_enter_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (enter_i && !clr_i) |=> mode_q == MODE_BIN);
  assert_clr_wins_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (enter_i && clr_i) |=> mode_q == MODE_TEXT);
endmodule

// File: rtl/bpw_byte_seq.sv
module bpw_byte_seq #(
  parameter int unsigned N_PORTS = 5,
  parameter int unsigned BYTE_W  = 8
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      wr_i,
  input  logic                      eom_i,
  input  logic [BYTE_W-1:0]         data_i,
  input  logic                      wipe_i,
  input  logic                      rewind_i,
  output logic [N_PORTS*BYTE_W-1:0] ports_o,
  output logic                      done_o
);
  localparam int unsigned PW = (N_PORTS > 1) ? $clog2(N_PORTS) : 1;
  localparam logic [PW-1:0] LAST = PW'(N_PORTS - 1);

  logic [PW-1:0] pos_q;

  assign done_o = wr_i && (pos_q == LAST || eom_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 pos_q <= '0;
    else if (rewind_i || done_o) pos_q <= '0;
    else if (wr_i)               pos_q <= pos_q + 1'b1;
  end

  // slot g holds port g+1; position 0 addresses the highest port
  for (genvar g = 0; g < N_PORTS; g++) begin : g_port
    localparam logic [PW-1:0] SLOT = PW'(N_PORTS - 1 - g);
    logic [BYTE_W-1:0] port_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                      port_q <= '0;
      else if (wipe_i)                  port_q <= '0;
      else if (wr_i && pos_q == SLOT)   port_q <= data_i;
    end
    assign ports_o[g*BYTE_W +: BYTE_W] = port_q;
  end

  assert_pos_range_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pos_q <= LAST);
  assert_rewind_after_done_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> pos_q == '0);
  assert_ports_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_i && !wipe_i) |=> $stable(ports_o));
endmodule

// File: rtl/bin_port_writer.sv
module bin_port_writer
  import bpw_pkg::*;
#(
  parameter int unsigned N_PORTS    = 5,
  parameter int unsigned BYTE_W     = 8,
  parameter int unsigned STB_CYCLES = 750,
  parameter int unsigned CLR_CYCLES = 2500
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      bin_enter_i,
  input  logic                      dev_clr_i,
  input  logic                      byte_valid_i,
  input  logic                      byte_eom_i,
  input  logic [BYTE_W-1:0]         byte_data_i,
  output logic [N_PORTS*BYTE_W-1:0] port_data_o,
  output logic                      strobe_o,
  output logic                      clr_pulse_o,
  output logic                      bin_mode_o
);
  mode_e mode;
  logic  clr_fire, mode_exit, wr, grp_done;

  bpw_mode_ctrl u_mode (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .enter_i    (bin_enter_i),
    .clr_i      (dev_clr_i),
    .mode_o     (mode),
    .clr_fire_o (clr_fire),
    .exit_o     (mode_exit)
  );

  // a byte in the clear cycle still belongs to binary mode
  assign wr = byte_valid_i && (mode == MODE_BIN);

  bpw_byte_seq #(.N_PORTS(N_PORTS), .BYTE_W(BYTE_W)) u_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_i     (wr),
    .eom_i    (byte_eom_i),
    .data_i   (byte_data_i),
    .wipe_i   (clr_fire),
    .rewind_i (mode_exit || clr_fire),
    .ports_o  (port_data_o),
    .done_o   (grp_done)
  );

  bpw_pulse_timer #(.CYCLES(STB_CYCLES)) u_stb (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (grp_done),
    .active_o (strobe_o)
  );

  bpw_pulse_timer #(.CYCLES(CLR_CYCLES)) u_clr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (clr_fire),
    .active_o (clr_pulse_o)
  );

  assign bin_mode_o = (mode == MODE_BIN);

  assert_no_clr_in_bin_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dev_clr_i && bin_mode_o) |=> !$rose(clr_pulse_o));
  assert_text_ignores_bytes_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_valid_i && !bin_mode_o && !dev_clr_i) |=> $stable(port_data_o));
  assert_clr_wipes_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dev_clr_i && !bin_mode_o) |=> (port_data_o == '0 && clr_pulse_o));
  assert_clr_byte_kept_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dev_clr_i && bin_mode_o && byte_valid_i) |=> !bin_mode_o);
endmodule

// File: tb/bin_port_writer_test.sv
`timescale 1ns/1ps
module bin_port_writer_test;
  localparam int STB = 750;
  localparam int CLR = 2500;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bin_enter = 1'b0, dev_clr = 1'b0, byte_valid = 1'b0, byte_eom = 1'b0;
  logic [7:0]  byte_data = '0;
  logic [39:0] port_data;
  logic        strobe, clr_pulse, bin_mode;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  bin_port_writer #(.N_PORTS(5), .BYTE_W(8), .STB_CYCLES(STB), .CLR_CYCLES(CLR)) uut (
    .clk_i(clk), .rst_ni(rst_n), .bin_enter_i(bin_enter), .dev_clr_i(dev_clr),
    .byte_valid_i(byte_valid), .byte_eom_i(byte_eom), .byte_data_i(byte_data),
    .port_data_o(port_data), .strobe_o(strobe), .clr_pulse_o(clr_pulse),
    .bin_mode_o(bin_mode)
  );

  // {eom, data}
  localparam logic [8:0] VEC [16] = '{
    9'h011, 9'h022, 9'h033, 9'h044, 9'h055,
    9'h066, 9'h177,
    9'h088, 9'h099, 9'h1AA,
    9'h1BB,
    9'h0C1, 9'h0C2, 9'h0C3, 9'h0C4, 9'h0C5
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] d, input logic e, input logic c);
    byte_valid = 1'b1; byte_data = d; byte_eom = e; dev_clr = c;
    @(negedge clk);
    byte_valid = 1'b0; byte_eom = 1'b0; dev_clr = 1'b0;
  endtask

  task automatic pulse_in(input logic enter, input logic c);
    bin_enter = enter; dev_clr = c;
    @(negedge clk);
    bin_enter = 1'b0; dev_clr = 1'b0;
  endtask

  task automatic measure_strobe(output int n);
    n = 0;
    while (strobe) begin n++; @(negedge clk); end
  endtask

  task automatic measure_clr(output int n);
    n = 0;
    while (clr_pulse) begin n++; @(negedge clk); end
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog act=expired exp=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : main
    logic [7:0]  exp_p [5];
    logic [39:0] pk;
    int pos, n;
    bit done;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 ports", port_data, 40'h0);
    chk("R1 mode", bin_mode, 1'b0);
    chk("R1 strobe", strobe, 1'b0);
    chk("R1 clr", clr_pulse, 1'b0);

    // R8 text-mode bytes ignored
    send(8'h5A, 1'b1, 1'b0);
    chk("R8 ports", port_data, 40'h0);
    chk("R8 strobe", strobe, 1'b0);

    // R12 clear plus enter: clear wins; R10 pulse length
    pulse_in(1'b1, 1'b1);
    chk("R12 mode", bin_mode, 1'b0);
    measure_clr(n);
    chk("R10 clr len", n, CLR);

    // R2 enter
    pulse_in(1'b1, 1'b0);
    chk("R2 mode", bin_mode, 1'b1);

    // table walk: R3 order, R5 short groups, R6 rewind
    for (int g = 0; g < 5; g++) exp_p[g] = 8'h00;
    pos = 0;
    for (int i = 0; i < 16; i++) begin
      send(VEC[i][7:0], VEC[i][8], 1'b0);
      exp_p[4-pos] = VEC[i][7:0];
      done = (pos == 4) || VEC[i][8];
      pos = done ? 0 : pos + 1;
      for (int g = 0; g < 5; g++) pk[g*8 +: 8] = exp_p[g];
      chk($sformatf("R3/R5/R6 ports vec%0d", i), port_data, pk);
      if (i < 4) chk("R4 no early strobe", strobe, 1'b0);
      if (done) chk("R4/R5 strobe", strobe, 1'b1);
    end

    // R4 exact strobe width
    repeat (STB + 5) @(negedge clk);
    chk("R4 idle", strobe, 1'b0);
    for (int i = 0; i < 5; i++) send(8'h10 + 8'(i), 1'b0, 1'b0);
    chk("R4 ports", port_data, 40'h1011121314);
    measure_strobe(n);
    chk("R4 strobe len", n, STB);

    // R7 bytes during strobe, restart
    for (int i = 0; i < 5; i++) send(8'h20 + 8'(i), 1'b0, 1'b0);
    repeat (100) @(negedge clk);
    for (int i = 0; i < 4; i++) send(8'h30 + 8'(i), 1'b0, 1'b0);
    chk("R7 strobe held", strobe, 1'b1);
    chk("R7 ports", port_data, 40'h3031323324);
    send(8'h34, 1'b0, 1'b0);
    chk("R7 ports full", port_data, 40'h3031323334);
    measure_strobe(n);
    chk("R7 restart len", n, STB);

    // R11 completion and clear in one cycle
    for (int i = 0; i < 4; i++) send(8'h40 + 8'(i), 1'b0, 1'b0);
    send(8'h44, 1'b0, 1'b1);
    chk("R11 ports", port_data, 40'h4041424344);
    chk("R11 strobe", strobe, 1'b1);
    chk("R11 mode", bin_mode, 1'b0);
    chk("R9 no clr pulse", clr_pulse, 1'b0);
    repeat (3) @(negedge clk);
    chk("R9 clr still low", clr_pulse, 1'b0);
    repeat (STB + 5) @(negedge clk);

    // R9 clear after partial group: ports kept, position rewinds
    pulse_in(1'b1, 1'b0);
    send(8'h51, 1'b0, 1'b0);
    send(8'h52, 1'b0, 1'b0);
    pulse_in(1'b0, 1'b1);
    chk("R9 mode", bin_mode, 1'b0);
    chk("R9 ports kept", port_data, 40'h5152424344);
    chk("R9 clr low", clr_pulse, 1'b0);
    chk("R9 no strobe", strobe, 1'b0);
    pulse_in(1'b1, 1'b0);
    send(8'h61, 1'b1, 1'b0);
    chk("R9 rewind port5", port_data, 40'h6152424344);
    chk("R5 strobe", strobe, 1'b1);

    // R10 text clear wipes
    pulse_in(1'b0, 1'b1);
    pulse_in(1'b0, 1'b1);
    chk("R10 wiped", port_data, 40'h0);
    chk("R10 clr high", clr_pulse, 1'b1);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule